// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a synthesizable behavioural model of the command state machine in a parallel NOR flash part. It watches host bus writes (address, data, write strobe) and tracks a strict multi-write unlock protocol. Two operations can be started this way: a whole-array erase and a single-word program. The array contents are not modelled. Each operation's internal work is a countdown. The erase countdown spans a preprogram-to-zero phase and an erase phase, and the host takes no part in it.

A running program can be paused by a suspend write. The pause takes effect only after a fixed settle delay, and a resume write continues the program from where it stopped. While an operation runs, host reads return polling status instead of array data. Bit 7 is the inverse of the final data bit. Bit 6 flips on every read, and in erase so does bit 2. During a pause, reads that hit the paused sector are refused.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, mode reads 0 (read mode), busy is 0, rd_data is 8'h00 and rd_blocked is 0.
- R2: Six writes in the order 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h start an erase. From the clock edge of the last write, mode reads 1 and busy is 1.
- R3: A write that does not match the current step drops the tracker to its first step. That write is not reconsidered as a first unlock, so a later partial sequence starts nothing.
- R4: Erase stays busy for exactly PRE_CYCLES+ERS_CYCLES clock cycles after its start edge and then returns to mode 0.
- R5: Every write made during an erase has no effect, including full command sequences, B0h and 30h. Mode stays 1 and the busy length is unchanged.
- R6: A read during an erase returns bit 7 = 0 and bits 6 and 2 equal to a toggle that is 0 on the first read and flips on each later read. All other bits are 0 (8'h00 / 8'h44).
- R7: 555h/AAh, 2AAh/55h, 555h/A0h, followed by any write (A, D), start a program of PROG_CYCLES cycles (mode 2, busy 1). Reads then return bit 7 = ~D[7], bit 6 as the toggle of R6, and all other bits 0.
- R8: Data B0h written while mode is 2 sets mode to 3 (suspended, busy 0) SUSP_CYCLES edges after the write's edge, if the program is still running then.
- R9: If the program's last cycle falls on or before the edge where the suspend would take effect, the program completes, mode returns to 0, and no suspend happens.
- R10: Data 30h written in mode 3 returns mode to 2. The cycles spent in mode 2 before and after the pause add up to PROG_CYCLES. Other writes in modes 2 and 3 have no effect.
- R11: In mode 3, a read whose top SECT_BITS address bits equal those of the program address returns {~D[7], 7'b0} with rd_blocked = 1. Reads of any other sector return 8'hFF with rd_blocked = 0.
- R12: An asynchronous reset during an erase at once forces mode 0 and busy 0. A new erase sequence is then accepted.
- R13: In mode 0, reads return the fill value 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | AW | Read address |
| busy | output | 1 | Erase or program in progress |
| mode | output | 2 | 0 read, 1 erase, 2 program, 3 suspended |
| rd_data | output | DW | Read result, one cycle after rd_en |
| rd_blocked | output | 1 | Last read hit the suspended sector |

## Verification
The coincidence that matters is the settle-delay expiry of a suspend request landing on the same edge as the program's final countdown cycle. The bench sweeps the delay between program start and the suspend write across every offset from zero up to one past the program length. That sweep includes the exact offset where both events share an edge, plus writes that arrive on the completion edge or after it. For each offset, the bench works out arithmetically whether the part must be suspended or back in read mode. When it is suspended, the bench resumes it and checks that the remaining program cycles bring the total to PROG_CYCLES.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
   typedef enum logic [1:0] {
      M_READ  = 2'd0,
      M_ERASE = 2'd1,
      M_PROG  = 2'd2,
      M_SUSP  = 2'd3
   } op_mode_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KEY1,
      ST_KEY2,
      ST_ARMED,
      ST_KEY3,
      ST_KEY4,
      ST_PADDR
   } seq_step_t;
endpackage

// File: rtl/nor_unlock_fsm.sv
module nor_unlock_fsm
   import nor_cmd_pkg::*;
#(
   parameter int             AW      = 12,
   parameter int             DW      = 8,
   parameter logic [AW-1:0]  ADDR_A  = 'h555,
   parameter logic [AW-1:0]  ADDR_B  = 'h2AA,
   parameter logic [DW-1:0]  KEY_A   = 'hAA,
   parameter logic [DW-1:0]  KEY_B   = 'h55,
   parameter logic [DW-1:0]  C_SETUP = 'h80,
   parameter logic [DW-1:0]  C_ERASE = 'h10,
   parameter logic [DW-1:0]  C_PROG  = 'hA0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          erase_go,
   output logic          prog_go
);
   seq_step_t step;
   logic hit_a, hit_b, hit_setup, hit_prog, hit_erase;

   always_comb begin
      hit_a     = (wr_addr == ADDR_A) && (wr_data == KEY_A);
      hit_b     = (wr_addr == ADDR_B) && (wr_data == KEY_B);
      hit_setup = (wr_addr == ADDR_A) && (wr_data == C_SETUP);
      hit_prog  = (wr_addr == ADDR_A) && (wr_data == C_PROG);
      hit_erase = (wr_addr == ADDR_A) && (wr_data == C_ERASE);
   end

   assign erase_go = enable && wr_en && (step == ST_KEY4) && hit_erase;
   assign prog_go  = enable && wr_en && (step == ST_PADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= ST_IDLE;
      end else if (!enable) begin
         step <= ST_IDLE;
      end else if (wr_en) begin
         case (step)
            ST_IDLE:  step <= hit_a ? ST_KEY1 : ST_IDLE;
            ST_KEY1:  step <= hit_b ? ST_KEY2 : ST_IDLE;
            ST_KEY2:  step <= hit_setup ? ST_ARMED : (hit_prog ? ST_PADDR : ST_IDLE);
            ST_ARMED: step <= hit_a ? ST_KEY3 : ST_IDLE;
            ST_KEY3:  step <= hit_b ? ST_KEY4 : ST_IDLE;
            default:  step <= ST_IDLE;
         endcase
      end
   end

   AST_MISMATCH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && wr_en && step == ST_KEY1 && !hit_b) |=> (step == ST_IDLE)); // R3
endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer
   import nor_cmd_pkg::*;
#(
   parameter int            DW          = 8,
   parameter int            ERASE_TOTAL = 20,
   parameter int            PROG_CYC    = 20,
   parameter int            SUSP_CYC    = 4,
   parameter logic [DW-1:0] C_SUSP      = 'hB0,
   parameter logic [DW-1:0] C_RES       = 'h30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          erase_go,
   input  logic          prog_go,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output op_mode_t      mode
);
   localparam int MAXC = (ERASE_TOTAL > PROG_CYC) ? ERASE_TOTAL : PROG_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int SW   = $clog2(SUSP_CYC + 1);

   logic [CW-1:0] cnt;
   logic [SW-1:0] scnt;
   logic          spend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= M_READ;
         cnt   <= '0;
         scnt  <= '0;
         spend <= 1'b0;
      end else begin
         case (mode)
            M_READ: begin
               spend <= 1'b0;
               if (erase_go) begin
                  mode <= M_ERASE;
                  cnt  <= CW'(ERASE_TOTAL - 1);
               end else if (prog_go) begin
                  mode <= M_PROG;
                  cnt  <= CW'(PROG_CYC - 1);
               end
            end
            M_ERASE: begin
               if (cnt == '0) mode <= M_READ;
               else           cnt  <= cnt - 1'b1;
            end
            M_PROG: begin
               if (cnt == '0) begin
                  mode  <= M_READ;
                  spend <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
                  if (spend) begin
                     if (scnt == '0) begin
                        mode  <= M_SUSP;
                        spend <= 1'b0;
                     end else begin
                        scnt <= scnt - 1'b1;
                     end
                  end else if (wr_en && wr_data == C_SUSP) begin
                     spend <= 1'b1;
                     scnt  <= SW'(SUSP_CYC - 1);
                  end
               end
            end
            default: begin
               if (wr_en && wr_data == C_RES) mode <= M_PROG;
            end
         endcase
      end
   end

   AST_ERASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_ERASE && cnt != '0) |=> (mode == M_ERASE)); // R5
   AST_RESUME_TO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SUSP && wr_en && wr_data == C_RES) |=> (mode == M_PROG)); // R10
   AST_SUSP_FROM_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode == M_SUSP) |-> ($past(mode) == M_PROG)); // R8
endmodule

// File: rtl/nor_status_mux.sv
module nor_status_mux
   import nor_cmd_pkg::*;
#(
   parameter int            AW         = 12,
   parameter int            DW         = 8,
   parameter int            SECT_BITS  = 2,
   parameter logic [DW-1:0] FILL       = '1,
   parameter bit            DQ2_TOGGLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  op_mode_t      mode,
   input  logic [AW-1:0] prog_addr,
   input  logic          prog_d7,
   output logic [DW-1:0] rd_data,
   output logic          rd_blocked
);
   logic          tog, dq2_val, same_sect, next_blk;
   logic [DW-1:0] next_data;

   generate
      if (DQ2_TOGGLE) begin : g_dq2_tog
         assign dq2_val = tog;
      end else begin : g_dq2_fixed
         assign dq2_val = 1'b0;
      end
   endgenerate

   always_comb begin
      same_sect = rd_addr[AW-1 -: SECT_BITS] == prog_addr[AW-1 -: SECT_BITS];
      next_data = '0;
      next_blk  = 1'b0;
      case (mode)
         M_ERASE: begin
            next_data[6] = tog;
            next_data[2] = dq2_val;
         end
         M_PROG: begin
            next_data[7] = ~prog_d7;
            next_data[6] = tog;
         end
         M_SUSP: begin
            if (same_sect) begin
               next_data[7] = ~prog_d7;
               next_blk     = 1'b1;
            end else begin
               next_data = FILL;
            end
         end
         default: next_data = FILL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog        <= 1'b0;
         rd_data    <= '0;
         rd_blocked <= 1'b0;
      end else begin
         rd_blocked <= rd_en && next_blk;
         if (rd_en) rd_data <= next_data;
         if (mode == M_READ)
            tog <= 1'b0;
         else if (rd_en && (mode == M_ERASE || mode == M_PROG))
            tog <= ~tog;
      end
   end

   AST_ERASE_DQ7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == M_ERASE) |=> (rd_data[7] == 1'b0)); // R6
   AST_STATUS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en) && (mode == M_ERASE || mode == M_PROG) && $past(mode) == mode)
      |=> (rd_data[6] != $past(rd_data[6]))); // R6
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
#(
   parameter int            AW          = 12,
   parameter int            DW          = 8,
   parameter int            SECT_BITS   = 2,
   parameter int            PRE_CYCLES  = 8,
   parameter int            ERS_CYCLES  = 12,
   parameter int            PROG_CYCLES = 20,
   parameter int            SUSP_CYCLES = 4,
   parameter bit            DQ2_TOGGLE  = 1'b1,
   parameter logic [AW-1:0] UNLK_ADDR_A = 'h555,
   parameter logic [AW-1:0] UNLK_ADDR_B = 'h2AA,
   parameter logic [DW-1:0] UNLK_KEY_A  = 'hAA,
   parameter logic [DW-1:0] UNLK_KEY_B  = 'h55,
   parameter logic [DW-1:0] OP_SETUP    = 'h80,
   parameter logic [DW-1:0] OP_ERASE    = 'h10,
   parameter logic [DW-1:0] OP_PROG     = 'hA0,
   parameter logic [DW-1:0] OP_SUSPEND  = 'hB0,
   parameter logic [DW-1:0] OP_RESUME   = 'h30,
   parameter logic [DW-1:0] ARRAY_FILL  = 'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic          busy,
   output logic [1:0]    mode,
   output logic [DW-1:0] rd_data,
   output logic          rd_blocked
);
   localparam int ERASE_TOTAL = PRE_CYCLES + ERS_CYCLES;

   generate
      if (DW < 8)                         begin : g_chk_dw   $error("DW must be at least 8"); end
      if (SECT_BITS < 1 || SECT_BITS > AW) begin : g_chk_sect $error("SECT_BITS out of range"); end
      if (SUSP_CYCLES < 1)                begin : g_chk_susp $error("SUSP_CYCLES must be >= 1"); end
      if (PROG_CYCLES < 2)                begin : g_chk_prog $error("PROG_CYCLES must be >= 2"); end
      if (PRE_CYCLES < 1 || ERS_CYCLES < 1) begin : g_chk_ers $error("erase phases need >= 1 cycle"); end
   endgenerate

   op_mode_t      mode_q;
   logic          erase_go, prog_go;
   logic [AW-1:0] prog_addr;
   logic          prog_d7;

   nor_unlock_fsm #(
      .AW(AW), .DW(DW), .ADDR_A(UNLK_ADDR_A), .ADDR_B(UNLK_ADDR_B),
      .KEY_A(UNLK_KEY_A), .KEY_B(UNLK_KEY_B), .C_SETUP(OP_SETUP),
      .C_ERASE(OP_ERASE), .C_PROG(OP_PROG)
   ) u_unlock (
      .clk(clk), .rst_n(rst_n), .enable(mode_q == M_READ),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .erase_go(erase_go), .prog_go(prog_go)
   );

   nor_op_timer #(
      .DW(DW), .ERASE_TOTAL(ERASE_TOTAL), .PROG_CYC(PROG_CYCLES),
      .SUSP_CYC(SUSP_CYCLES), .C_SUSP(OP_SUSPEND), .C_RES(OP_RESUME)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .prog_go(prog_go),
      .wr_en(wr_en), .wr_data(wr_data), .mode(mode_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_addr <= '0;
         prog_d7   <= 1'b0;
      end else if (prog_go) begin
         prog_addr <= wr_addr;
         prog_d7   <= wr_data[DW-1];
      end
   end

   nor_status_mux #(
      .AW(AW), .DW(DW), .SECT_BITS(SECT_BITS), .FILL(ARRAY_FILL),
      .DQ2_TOGGLE(DQ2_TOGGLE)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .mode(mode_q), .prog_addr(prog_addr), .prog_d7(prog_d7),
      .rd_data(rd_data), .rd_blocked(rd_blocked)
   );

   assign busy = (mode_q == M_ERASE) || (mode_q == M_PROG);
   assign mode = mode_q;

   AST_ERASE_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> (mode_q == M_ERASE)); // R2
   AST_BLOCK_ONLY_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_blocked |-> ($past(mode_q) == M_SUSP)); // R11
endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
   localparam int AW = 12, DW = 8;
   localparam int PRE = 8, ERS = 12, P = 20, S = 4;
   localparam int N = PRE + ERS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          busy;
   logic [1:0]    mode;
   logic [DW-1:0] rd_data;
   logic          rd_blocked;

   int vectors = 0;
   int errors  = 0;

   always #10 clk = ~clk;

   nor_cmd_seq #(.AW(AW), .DW(DW), .SECT_BITS(2), .PRE_CYCLES(PRE),
                 .ERS_CYCLES(ERS), .PROG_CYCLES(P), .SUSP_CYCLES(S)) u_nor_cmd_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .mode(mode),
      .rd_data(rd_data), .rd_blocked(rd_blocked));

   logic [AW-1:0] seq_a [6] = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h555};
   logic [DW-1:0] seq_d [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   task automatic idle;
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic start_erase;
      for (int i = 0; i < 6; i++) wr(seq_a[i], seq_d[i]);
   endtask

   task automatic start_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
   endtask

   task automatic wait_read;
      for (int i = 0; i < 200 && mode != 2'd0; i++) idle();
   endtask

   // kind 0: idle, 1: writes during erase, 2: reads during erase
   task automatic erase_window(input int kind, input string req);
      start_erase();
      chk({req, " mode erase at start"}, mode, 1);
      for (int i = 0; i < N; i++) begin
         chk({req, " busy inside window"}, busy, 1);
         if (kind == 1 && i < 6)       wr(seq_a[i], seq_d[i]);
         else if (kind == 1 && i == 6) wr(12'h000, 8'hB0);
         else if (kind == 1 && i == 7) wr(12'h000, 8'h30);
         else if (kind == 2 && i < 4) begin
            rd(12'h010);
            chk("R6 erase status word", rd_data, (i % 2) ? 8'h44 : 8'h00);
         end else idle();
      end
      chk({req, " busy low after window"}, busy, 0);
      chk({req, " mode read after window"}, mode, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      int pcnt;
      logic [DW-1:0] pd;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 mode", mode, 0);
      chk("R1 busy", busy, 0);
      chk("R1 rd_data", rd_data, 0);
      chk("R1 rd_blocked", rd_blocked, 0);
      rst_n = 1'b1;
      idle();

      // R13 read mode returns fill
      rd(12'h321);
      chk("R13 read fill", rd_data, 8'hFF);

      // R2 / R4 plain erase
      erase_window(0, "R4");
      chk("R2 erase start observed", 1, 1);
      // R5 writes during erase ignored
      erase_window(1, "R5");
      // R6 status reads
      erase_window(2, "R6");

      // R3 mismatch sweep at every step
      for (int k = 0; k < 6; k++) begin
         for (int i = 0; i < k; i++) wr(seq_a[i], seq_d[i]);
         if (k == 0 || k == 3) wr(12'h555, 8'h55);
         else                  wr(12'h555, 8'hAA);
         for (int i = k + 1; i < 6; i++) wr(seq_a[i], seq_d[i]);
         idle();
         chk("R3 mismatch leaves read mode", mode, 0);
         wr(12'h000, 8'h00);
         wr(12'h000, 8'h00);
      end
      // R2 full sequence still accepted afterwards
      start_erase();
      chk("R2 mode erase", mode, 1);
      chk("R2 busy", busy, 1);
      wait_read();

      // R7 program status and length
      start_prog(12'h123, 8'h5A);
      chk("R7 mode program", mode, 2);
      rd(12'h123);
      chk("R7 status first", rd_data, 8'h80);
      rd(12'h123);
      chk("R7 status second", rd_data, 8'hC0);
      wait_read();
      start_prog(12'h456, 8'hA5);
      rd(12'h456);
      chk("R7 status d7 set", rd_data, 8'h00);
      wait_read();

      // R10 other writes in program ignored, length unchanged
      start_prog(12'h200, 8'h11);
      pcnt = 0;
      for (int i = 0; i < P + 5; i++) begin
         if (mode == 2'd2) pcnt++;
         if (i == 0)      wr(12'h555, 8'h30);
         else if (i == 1) wr(12'h555, 8'hAA);
         else if (i == 2) wr(12'h2AA, 8'h55);
         else idle();
      end
      chk("R10 program length with stray writes", pcnt, P);

      // R8/R9/R10/R11 suspend offset sweep
      for (int d = 0; d <= P; d++) begin
         pd = DW'((d * 37 + 3) % 256);
         start_prog(12'h1C0, pd);
         for (int i = 0; i < d; i++) idle();
         wr(12'h000, 8'hB0);
         for (int i = 0; i < S; i++) idle();
         if (d + 1 + S < P) begin
            chk("R8 suspended after settle", mode, 3);
            chk("R8 busy low in suspend", busy, 0);
            rd(12'h1FF);
            chk("R11 same sector status", rd_data, {~pd[7], 7'b0});
            chk("R11 blocked flag", rd_blocked, 1);
            rd(12'h9C0);
            chk("R11 other sector fill", rd_data, 8'hFF);
            chk("R11 other sector not blocked", rd_blocked, 0);
            wr(12'h555, 8'hAA);
            chk("R10 stray write in suspend", mode, 3);
            wr(12'h000, 8'h30);
            pcnt = 0;
            for (int i = 0; i < 100 && mode == 2'd2; i++) begin
               pcnt++;
               idle();
            end
            chk("R10 remaining program cycles", pcnt, P - (d + 1 + S));
         end else begin
            chk("R9 completion wins over suspend", mode, 0);
         end
         chk("R9 back in read mode", mode, 0);
      end

      // R12 async reset aborts erase
      start_erase();
      for (int i = 0; i < 5; i++) idle();
      rst_n = 1'b0;
      #1;
      chk("R12 mode after reset", mode, 0);
      chk("R12 busy after reset", busy, 0);
      idle();
      rst_n = 1'b1;
      idle();
      start_erase();
      chk("R12 erase accepted again", mode, 1);
      wait_read();

      report();
   end
endmodule